// File: doc/BRIEF.md
# Prioritized Interrupt State Vector Register

This block sits between the event outputs of a serial link controller and the CPU. Eight kinds of event (received end of frame, received in-frame-response byte, receive buffer full, transmit buffer empty, lost arbitration, CRC error, bad symbol and wakeup) each arrive as a one-cycle pulse. Each pulse sets a sticky pending flag. A priority encoder picks the most urgent pending flag and presents its 4-bit code, shifted left by two, as a read-only 8-bit vector. The CPU can add this vector straight to the base of a jump table whose entries are four bytes apart.

Most flags are dropped when the CPU reads the vector. The three flags that mean a data buffer needs service stay pending until the CPU completes a two-step sequence. It first reads the vector. It then reads the data register (for the receive kinds) or writes it (for the transmit kind). A one-bit armed latch, together with the captured code, tracks that sequence. The transmit flag can also be dropped directly by a transmit-end control strobe. An interrupt request is raised whenever any code is being reported.

Top module: `isv_top`

## Requirements
- R1: After synchronous reset the vector reads 0x00 and the interrupt request is low.
- R2: The vector is 8 bits with bits 7, 6, 1 and 0 always zero and bits 5..2 holding the code. The codes are: 0 none pending, 1 end of frame (event bit 0), 2 in-frame-response byte (bit 1), 3 receive full (bit 2), 4 transmit empty (bit 3), 5 arbitration lost (bit 4), 6 CRC error (bit 5), 7 bad symbol (bit 6), 8 wakeup (bit 7).
- R3: With several flags pending, only the highest code is reported. Codes 9 to 15 never appear.
- R4: A one-cycle event pulse sets a sticky flag that shows on the vector in the cycle after the pulse.
- R5: A vector read drops the flag of the reported code when that code is 1, 5, 6, 7 or 8. The next pending source is shown in the following cycle.
- R6: A vector read leaves codes 2, 3 and 4 pending.
- R7: After a vector read that reported code 2 or 3, a data-register read drops that flag. A data-register write does not drop it.
- R8: After a vector read that reported code 4, a data-register write drops that flag. A data-register read does not drop it.
- R9: A transmit-end strobe drops the code-4 flag without any vector read.
- R10: A data-register read or write with no arming vector read before it changes no flag.
- R11: An event pulse in the same cycle as the clear of its flag leaves the flag pending.
- R12: The interrupt request is high exactly when the reported code is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 8 | One-cycle event pulses, bit k for code k+1 |
| vec_rd_i | input | 1 | Vector register read strobe |
| dat_rd_i | input | 1 | Data register read strobe |
| dat_wr_i | input | 1 | Data register write strobe |
| tx_end_i | input | 1 | Transmit-end-of-data control strobe |
| vec_o | output | 8 | State vector, code times four |
| irq_o | output | 1 | Interrupt request |

## Verification
A new event pulse can land in the same cycle as the clear of its own flag. That clear may come from a vector read, from the completing data access, or from the transmit-end strobe. A second collision is a vector read that arrives in the same cycle as a data access, so the capture and the completion overlap. Both cases are forced in directed steps and also come up often under random strobes. They are judged against a cycle-level bench model in which the set has priority and the data access acts on the code captured earlier.

// File: rtl/isv_pkg.sv
package isv_pkg;
    parameter int SRC_N    = 8;
    parameter int CODE_W   = 4;
    parameter int VEC_W    = 8;
    parameter int CODE_LSB = 2;
    localparam int IDX_W   = $clog2(SRC_N);

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [SRC_N-1:0]  src_vec_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef enum logic [CODE_W-1:0] {
        SRC_NONE = 4'd0,
        SRC_EOF  = 4'd1,
        SRC_IFR  = 4'd2,
        SRC_RXF  = 4'd3,
        SRC_TXE  = 4'd4,
        SRC_ARB  = 4'd5,
        SRC_CRC  = 4'd6,
        SRC_SYM  = 4'd7,
        SRC_WAKE = 4'd8
    } src_code_e;

    typedef struct packed {
        logic vec_rd;
        logic dat_rd;
        logic dat_wr;
        logic tx_end;
    } bus_t;

    typedef struct packed {
        logic      armed;
        src_code_e cap;
    } arm_t;

    function automatic logic is_rx_svc(code_t c);
        return (c == SRC_IFR) || (c == SRC_RXF);
    endfunction

    function automatic logic is_tx_svc(code_t c);
        return c == SRC_TXE;
    endfunction

    function automatic logic is_data_svc(code_t c);
        return is_rx_svc(c) || is_tx_svc(c);
    endfunction

    function automatic idx_t flag_idx(code_t c);
        return idx_t'(c - code_t'(1));
    endfunction

    function automatic logic [VEC_W-1:0] vec_of(code_t c);
        return VEC_W'(c) << CODE_LSB;
    endfunction
endpackage

// File: rtl/isv_flag_bank.sv
module isv_flag_bank
    import isv_pkg::*;
#(
    parameter int N = SRC_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                pend_o[i] <= 1'b0;
            else if (set_i[i])
                pend_o[i] <= 1'b1;
            else if (clr_i[i])
                pend_o[i] <= 1'b0;
        end

        // R4 R11
        flag_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> pend_o[i]);

        // R5
        flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
            clr_i[i] && !set_i[i] |=> !pend_o[i]);
    end
endmodule

// File: rtl/isv_prio_enc.sv
module isv_prio_enc
    import isv_pkg::*;
#(
    parameter int N  = SRC_N,
    parameter int CW = CODE_W
) (
    input  logic [N-1:0]  pend_i,
    output logic [CW-1:0] code_o
);
    always_comb begin
        code_o = '0;
        for (int k = 0; k < N; k++) begin
            if (pend_i[k])
                code_o = CW'(k + 1);
        end
    end
endmodule

// File: rtl/isv_clear_seq.sv
module isv_clear_seq
    import isv_pkg::*;
#(
    parameter int N = SRC_N
) (
    input  logic         clk,
    input  logic         rst,
    input  bus_t         bus_i,
    input  code_t        code_i,
    output logic [N-1:0] clr_o,
    output logic         armed_o
);
    arm_t st;
    logic disarm;

    assign armed_o = st.armed;

    always_comb begin
        clr_o  = '0;
        disarm = 1'b0;
        if (bus_i.vec_rd && code_i != SRC_NONE && !is_data_svc(code_i))
            clr_o[flag_idx(code_i)] = 1'b1;
        if (bus_i.dat_rd && st.armed && is_rx_svc(st.cap)) begin
            clr_o[flag_idx(st.cap)] = 1'b1;
            disarm = 1'b1;
        end
        if (bus_i.dat_wr && st.armed && is_tx_svc(st.cap)) begin
            clr_o[flag_idx(SRC_TXE)] = 1'b1;
            disarm = 1'b1;
        end
        if (bus_i.tx_end) begin
            clr_o[flag_idx(SRC_TXE)] = 1'b1;
            if (st.armed && is_tx_svc(st.cap))
                disarm = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.armed <= 1'b0;
            st.cap   <= SRC_NONE;
        end else if (bus_i.vec_rd) begin
            st.armed <= is_data_svc(code_i);
            st.cap   <= src_code_e'(code_i);
        end else if (disarm) begin
            st.armed <= 1'b0;
        end
    end

    // R10
    idle_data_chk: assert property (@(posedge clk) disable iff (rst)
        !st.armed && !bus_i.vec_rd && !bus_i.tx_end |-> clr_o == '0);

    // R7
    arm_rx_chk: assert property (@(posedge clk) disable iff (rst)
        bus_i.vec_rd && is_rx_svc(code_i) |=> st.armed);
endmodule

// File: rtl/isv_top.sv
module isv_top
    import isv_pkg::*;
#(
    parameter int N = SRC_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     evt_i,
    input  logic             vec_rd_i,
    input  logic             dat_rd_i,
    input  logic             dat_wr_i,
    input  logic             tx_end_i,
    output logic [VEC_W-1:0] vec_o,
    output logic             irq_o
);
    logic [N-1:0] pend;
    logic [N-1:0] clr;
    code_t        code;
    logic         armed;
    bus_t         bus;

    assign bus.vec_rd = vec_rd_i;
    assign bus.dat_rd = dat_rd_i;
    assign bus.dat_wr = dat_wr_i;
    assign bus.tx_end = tx_end_i;

    isv_flag_bank #(.N(N)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .set_i (evt_i),
        .clr_i (clr),
        .pend_o(pend)
    );

    isv_prio_enc #(.N(N), .CW(CODE_W)) u_enc (
        .pend_i(pend),
        .code_o(code)
    );

    isv_clear_seq #(.N(N)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .bus_i  (bus),
        .code_i (code),
        .clr_o  (clr),
        .armed_o(armed)
    );

    assign vec_o = vec_of(code);
    assign irq_o = code != SRC_NONE;

    // R3
    top_src_chk: assert property (@(posedge clk) disable iff (rst)
        pend[N-1] |-> code == code_t'(N));

    // R3
    none_pending_chk: assert property (@(posedge clk) disable iff (rst)
        pend == '0 |-> code == SRC_NONE);

    // R5
    vec_clr_chk: assert property (@(posedge clk) disable iff (rst)
        vec_rd_i && code != SRC_NONE && !is_data_svc(code) |-> clr[flag_idx(code)]);

    // R6
    data_keep_chk: assert property (@(posedge clk) disable iff (rst)
        vec_rd_i && is_data_svc(code) && !armed && !tx_end_i |-> !clr[flag_idx(code)]);
endmodule

// File: tb/isv_top_test.sv
`timescale 1ns/1ps
module isv_top_test;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] evt;
    logic       vr, dr, dw, te;
    logic [7:0] vec_o;
    logic       irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] m_pend;
    bit         m_armed;
    int         m_cap;

    always #10 clk = ~clk;

    isv_top uut (
        .clk(clk), .rst(rst), .evt_i(evt), .vec_rd_i(vr), .dat_rd_i(dr),
        .dat_wr_i(dw), .tx_end_i(te), .vec_o(vec_o), .irq_o(irq_o)
    );

    function automatic int top_code(logic [7:0] p);
        int c = 0;
        for (int k = 0; k < 8; k++) if (p[k]) c = k + 1;
        return c;
    endfunction

    function automatic bit rx_kind(int c);
        return c == 2 || c == 3;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic model_update();
        int c = top_code(m_pend);
        logic [7:0] clr = '0;
        bit dis = 0;
        if (vr && c != 0 && !(rx_kind(c) || c == 4)) clr[c-1] = 1'b1;
        if (dr && m_armed && rx_kind(m_cap)) begin clr[m_cap-1] = 1'b1; dis = 1; end
        if (dw && m_armed && m_cap == 4) begin clr[3] = 1'b1; dis = 1; end
        if (te) begin clr[3] = 1'b1; if (m_armed && m_cap == 4) dis = 1; end
        if (vr) begin m_armed = rx_kind(c) || c == 4; m_cap = c; end
        else if (dis) m_armed = 0;
        m_pend = (m_pend & ~clr) | evt;
    endtask

    task automatic step(logic [7:0] e, bit r, bit d_r, bit d_w, bit t);
        evt = e; vr = r; dr = d_r; dw = d_w; te = t;
        @(posedge clk);
        model_update();
        @(negedge clk);
        chk("R3", vec_o, top_code(m_pend) * 4);
        chk("R12", irq_o, m_pend != 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        evt = 0; vr = 0; dr = 0; dw = 0; te = 0; rst = 1'b1;
        m_pend = 0; m_armed = 0; m_cap = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1", vec_o, 8'h00);
        chk("R1", irq_o, 0);

        step(8'h01, 0, 0, 0, 0); chk("R4", vec_o, 8'h04); chk("R2", vec_o & 8'hC3, 0);
        step(8'h00, 0, 0, 0, 0); chk("R4", vec_o, 8'h04);
        step(8'h80, 0, 0, 0, 0); chk("R3", vec_o, 8'h20);
        step(8'h00, 1, 0, 0, 0); chk("R5", vec_o, 8'h04);
        step(8'h00, 1, 0, 0, 0); chk("R5", vec_o, 8'h00); chk("R12", irq_o, 0);

        step(8'h04, 0, 0, 0, 0); chk("R2", vec_o, 8'h0C);
        step(8'h00, 1, 0, 0, 0); chk("R6", vec_o, 8'h0C);
        step(8'h00, 0, 0, 1, 0); chk("R7", vec_o, 8'h0C);
        step(8'h00, 0, 1, 0, 0); chk("R7", vec_o, 8'h00);

        step(8'h02, 0, 0, 0, 0); chk("R2", vec_o, 8'h08);
        step(8'h00, 1, 0, 0, 0); chk("R6", vec_o, 8'h08);
        step(8'h00, 0, 1, 0, 0); chk("R7", vec_o, 8'h00);

        step(8'h08, 0, 0, 0, 0); chk("R2", vec_o, 8'h10);
        step(8'h00, 0, 0, 1, 0); chk("R10", vec_o, 8'h10);
        step(8'h00, 0, 1, 0, 0); chk("R10", vec_o, 8'h10);
        step(8'h00, 1, 0, 0, 0); chk("R6", vec_o, 8'h10);
        step(8'h00, 0, 1, 0, 0); chk("R8", vec_o, 8'h10);
        step(8'h00, 0, 0, 1, 0); chk("R8", vec_o, 8'h00);

        step(8'h08, 0, 0, 0, 0);
        step(8'h00, 0, 0, 0, 1); chk("R9", vec_o, 8'h00);

        step(8'h01, 0, 0, 0, 0);
        step(8'h01, 1, 0, 0, 0); chk("R11", vec_o, 8'h04);
        step(8'h00, 1, 0, 0, 0); chk("R11", vec_o, 8'h00);
        step(8'h08, 0, 0, 0, 0);
        step(8'h08, 0, 0, 0, 1); chk("R11", vec_o, 8'h10);
        step(8'h00, 0, 0, 0, 1); chk("R9", vec_o, 8'h00);

        step(8'hFF, 0, 0, 0, 0); chk("R3", vec_o, 8'h20);
        step(8'h00, 1, 0, 0, 0); chk("R5", vec_o, 8'h1C);
        step(8'h00, 1, 1, 0, 0); chk("R5", vec_o, 8'h18);

        for (int n = 0; n < 4000; n++) begin
            logic [7:0] e = 0;
            for (int b = 0; b < 8; b++) e[b] = ($urandom % 16) == 0;
            step(e, ($urandom % 4) == 0, ($urandom % 4) == 0,
                 ($urandom % 4) == 0, ($urandom % 12) == 0);
            chk("R2", vec_o & 8'hC3, 0);
            chk("R3", vec_o <= 8'h20, 1);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule